// File: doc/BRIEF.md
# DMA Descriptor Configuration Error Checker

This block inspects the fields of a DMA transfer descriptor at the moment a channel is about to run it. It raises flags for descriptor settings that cannot work. These are a destination address or destination offset that does not fit the destination transfer size, a minor-loop byte count that does not fit the transfer sizes, a zero or inconsistent iteration count, and a misaligned next-descriptor pointer when a scatter/gather load is about to happen. It also logs bus errors that the read path and the write path report while a transfer is in flight.

Only the most recent error is kept. Each new error overwrites every flag and records the channel number of the offending channel. A clear input wipes the record. The descriptor fetch logic drives the check strobe and the descriptor fields in the same cycle. The bus paths pulse their error lines for one cycle.

Top module: `dma_desc_err_check`

## Requirements
- R1: The flag errFlags[0] (destination address) is set when dstAddr is not a multiple of the destination transfer size. Size codes map as follows: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 32 bytes.
- R2: The flag errFlags[1] (destination offset) is set when dstOff is not a multiple of the destination transfer size.
- R3: The flag errFlags[2] (byte count / iteration) is set when minorBytes is not a multiple of both the source size and the destination size.
- R4: The flag errFlags[2] is set when the count field of the current iteration count, citer[14:0], is zero.
- R5: The flag errFlags[2] is set when the link-enable bit of the current count, citer[15], differs from biterLink.
- R6: A size code from 4 to 7 in either size field is reserved and sets errFlags[2]. When the destination code is reserved, the address check and the offset check are skipped.
- R7: The flag errFlags[3] (scatter/gather) is set when sgNextAddr[4:0] is non-zero, but only when chkSgLoad and sgEnable are both high. In all other cases the pointer has no effect on the status.
- R8: A rdBusErr pulse sets errFlags[4]. A wrBusErr pulse sets errFlags[5]. Pulses in the same cycle set both flags. The recorded channel is busChan. A bus error takes priority over a descriptor error in the same cycle.
- R9: A recorded error replaces all flags and the channel number, and sets errValid. A check that finds no fault leaves the status unchanged.
- R10: clrStat zeroes the flags, the channel and errValid. A new error in the same cycle as a clear is recorded instead.
- R11: After reset all status is zero. Each update appears one clock after the cycle that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chkValid | input | 1 | Descriptor check strobe |
| chkChan | input | 6 | Channel of the descriptor being checked |
| chkSgLoad | input | 1 | Check happens at a scatter/gather load after major-loop completion |
| srcSize | input | 3 | Source transfer size code |
| dstSize | input | 3 | Destination transfer size code |
| dstAddr | input | 32 | Destination address |
| dstOff | input | 16 | Destination offset |
| minorBytes | input | 32 | Minor-loop byte count |
| citer | input | 16 | Current iteration count; bit 15 is the link-enable bit |
| biterLink | input | 1 | Link-enable bit of the beginning count |
| sgEnable | input | 1 | Scatter/gather enabled in the descriptor |
| sgNextAddr | input | 32 | Next-descriptor address |
| rdBusErr | input | 1 | Read bus error pulse |
| wrBusErr | input | 1 | Write bus error pulse |
| busChan | input | 6 | Channel owning the bus transfer |
| clrStat | input | 1 | Clear the error record |
| errFlags | output | 6 | Flags: [0] dst addr, [1] dst offset, [2] count/iteration, [3] scatter/gather, [4] source bus, [5] destination bus |
| errChan | output | 6 | Channel of the last recorded error |
| errValid | output | 1 | An error is recorded |

## Verification
The bench checks the 32-byte size code, where a mask that is too narrow would pass addresses such as 0x10. It checks reserved size codes, where a design that decodes them as real sizes would also raise address or offset flags. It drives a misaligned next pointer with the load gate closed and then with it open, which exposes a design that checks the pointer on every descriptor. Same-cycle collisions of a bus error with a faulty descriptor, and of a clear with a new error, expose a wrong priority: the status would then show the descriptor's flags or would lose the new error.

// File: rtl/dcec_pkg.sv
package dcec_pkg;
  localparam int FLAG_W = 6;
  localparam int F_DA = 0;
  localparam int F_DO = 1;
  localparam int F_NB = 2;
  localparam int F_SG = 3;
  localparam int F_SB = 4;
  localparam int F_DB = 5;
  localparam int MASK_W = 5;

  typedef struct packed {
    logic clrAll;
    logic loadChk;
    logic loadBus;
  } statStrobe_t;

  function automatic logic sizeLegal(input logic [2:0] code);
    return code[2] == 1'b0;
  endfunction

  function automatic logic [MASK_W-1:0] sizeMask(input logic [2:0] code);
    case (code)
      3'd0:    return 5'b00000;
      3'd1:    return 5'b00001;
      3'd2:    return 5'b00011;
      3'd3:    return 5'b11111;
      default: return 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/dcec_ctrl.sv
module dcec_ctrl
  import dcec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chkValid,
  input  logic        chkErrAny,
  input  logic        rdBusErr,
  input  logic        wrBusErr,
  input  logic        clrStat,
  output statStrobe_t strobe
);
  logic busAny;

  always_comb begin
    busAny         = rdBusErr | wrBusErr;
    strobe.loadBus = busAny;
    strobe.loadChk = chkValid & chkErrAny & ~busAny;
    strobe.clrAll  = clrStat & ~busAny & ~(chkValid & chkErrAny);
  end

  // R8 / R10: at most one kind of status update per cycle
  a_r8_one_update: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrAll, strobe.loadChk, strobe.loadBus}));

  // R8: a bus error always wins over a descriptor error
  a_r8_bus_priority: assert property (@(posedge clk) disable iff (!rstN)
    (rdBusErr || wrBusErr) |-> !strobe.loadChk);
endmodule

// File: rtl/dcec_datapath.sv
module dcec_datapath
  import dcec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 16,
  parameter int NB_W     = 32,
  parameter int ITER_W   = 16,
  parameter int CHAN_W   = 6,
  parameter int SG_ALIGN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStrobe_t       strobe,
  input  logic              chkValid,
  input  logic [CHAN_W-1:0] chkChan,
  input  logic              chkSgLoad,
  input  logic [2:0]        srcSize,
  input  logic [2:0]        dstSize,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [OFF_W-1:0]  dstOff,
  input  logic [NB_W-1:0]   minorBytes,
  input  logic [ITER_W-1:0] citer,
  input  logic              biterLink,
  input  logic              sgEnable,
  input  logic [ADDR_W-1:0] sgNextAddr,
  input  logic              rdBusErr,
  input  logic              wrBusErr,
  input  logic [CHAN_W-1:0] busChan,
  output logic              chkErrAny,
  output logic [FLAG_W-1:0] errFlags,
  output logic [CHAN_W-1:0] errChan,
  output logic              errValid
);
  localparam int SG_LSB  = $clog2(SG_ALIGN);
  localparam int CNT_W   = ITER_W - 1;
  localparam int N_SIZES = 2;

  logic [N_SIZES-1:0][2:0]        sizeCode;
  logic [N_SIZES-1:0][MASK_W-1:0] sizeMsk;
  logic [N_SIZES-1:0]             sizeOk;
  logic [N_SIZES-1:0]             nbMisfit;
  logic [FLAG_W-1:0]              chkFlags;
  logic [ADDR_W-1:0]              sgMask;

  assign sizeCode[0] = srcSize;
  assign sizeCode[1] = dstSize;

  // one size decoder and byte-count fit test per transfer side
  for (genvar s = 0; s < N_SIZES; s++) begin : gSide
    assign sizeOk[s]   = sizeLegal(sizeCode[s]);
    assign sizeMsk[s]  = sizeMask(sizeCode[s]);
    assign nbMisfit[s] = (minorBytes & NB_W'(sizeMsk[s])) != '0;
  end

  assign sgMask = ADDR_W'((64'd1 << SG_LSB) - 64'd1);

  always_comb begin
    chkFlags       = '0;
    chkFlags[F_DA] = sizeOk[1] && ((dstAddr & ADDR_W'(sizeMsk[1])) != '0);
    chkFlags[F_DO] = sizeOk[1] && ((dstOff & OFF_W'(sizeMsk[1])) != '0);
    chkFlags[F_NB] = !(&sizeOk) || (|nbMisfit)
                     || (citer[CNT_W-1:0] == '0)
                     || (citer[ITER_W-1] != biterLink);
    chkFlags[F_SG] = chkSgLoad && sgEnable && ((sgNextAddr & sgMask) != '0);
    chkErrAny      = |chkFlags;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlags <= '0;
      errChan  <= '0;
      errValid <= 1'b0;
    end else if (strobe.loadBus) begin
      errFlags       <= '0;
      errFlags[F_SB] <= rdBusErr;
      errFlags[F_DB] <= wrBusErr;
      errChan        <= busChan;
      errValid       <= 1'b1;
    end else if (strobe.loadChk) begin
      errFlags <= chkFlags;
      errChan  <= chkChan;
      errValid <= 1'b1;
    end else if (strobe.clrAll) begin
      errFlags <= '0;
      errChan  <= '0;
      errValid <= 1'b0;
    end
  end

  // R1: misaligned 4-byte destination is recorded with the checked channel
  a_r1_dst_addr: assert property (@(posedge clk) disable iff (!rstN)
    chkValid && !rdBusErr && !wrBusErr && dstSize == 3'd2 && dstAddr[1:0] != 2'b00
    |=> errFlags[F_DA] && errValid && errChan == $past(chkChan));

  // R7: closed scatter/gather gate never raises the scatter/gather flag
  a_r7_sg_gate: assert property (@(posedge clk) disable iff (!rstN)
    !(chkSgLoad && sgEnable) |=> !errFlags[F_SG] || $past(errFlags[F_SG]));

  // R8: read bus error is logged against the bus channel
  a_r8_rd_bus: assert property (@(posedge clk) disable iff (!rstN)
    rdBusErr |=> errFlags[F_SB] && errValid && errChan == $past(busChan));

  // R9: empty record carries no flags and no channel
  a_r9_empty_record: assert property (@(posedge clk) disable iff (!rstN)
    !errValid |-> errFlags == '0 && errChan == '0);
endmodule

// File: rtl/dma_desc_err_check.sv
module dma_desc_err_check
  import dcec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 16,
  parameter int NB_W     = 32,
  parameter int ITER_W   = 16,
  parameter int CHAN_W   = 6,
  parameter int SG_ALIGN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chkValid,
  input  logic [CHAN_W-1:0] chkChan,
  input  logic              chkSgLoad,
  input  logic [2:0]        srcSize,
  input  logic [2:0]        dstSize,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [OFF_W-1:0]  dstOff,
  input  logic [NB_W-1:0]   minorBytes,
  input  logic [ITER_W-1:0] citer,
  input  logic              biterLink,
  input  logic              sgEnable,
  input  logic [ADDR_W-1:0] sgNextAddr,
  input  logic              rdBusErr,
  input  logic              wrBusErr,
  input  logic [CHAN_W-1:0] busChan,
  input  logic              clrStat,
  output logic [5:0]        errFlags,
  output logic [CHAN_W-1:0] errChan,
  output logic              errValid
);
  statStrobe_t strobe;
  logic        chkErrAny;

  dcec_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .chkValid  (chkValid),
    .chkErrAny (chkErrAny),
    .rdBusErr  (rdBusErr),
    .wrBusErr  (wrBusErr),
    .clrStat   (clrStat),
    .strobe    (strobe)
  );

  dcec_datapath #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .NB_W     (NB_W),
    .ITER_W   (ITER_W),
    .CHAN_W   (CHAN_W),
    .SG_ALIGN (SG_ALIGN)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .chkValid   (chkValid),
    .chkChan    (chkChan),
    .chkSgLoad  (chkSgLoad),
    .srcSize    (srcSize),
    .dstSize    (dstSize),
    .dstAddr    (dstAddr),
    .dstOff     (dstOff),
    .minorBytes (minorBytes),
    .citer      (citer),
    .biterLink  (biterLink),
    .sgEnable   (sgEnable),
    .sgNextAddr (sgNextAddr),
    .rdBusErr   (rdBusErr),
    .wrBusErr   (wrBusErr),
    .busChan    (busChan),
    .chkErrAny  (chkErrAny),
    .errFlags   (errFlags),
    .errChan    (errChan),
    .errValid   (errValid)
  );

  // R10: a lone clear empties the record on the next edge
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrStat && !chkValid && !rdBusErr && !wrBusErr
    |=> errFlags == '0 && errChan == '0 && !errValid);
endmodule

// File: tb/sim_dma_desc_err_check.sv
module sim_dma_desc_err_check;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chkValid, chkSgLoad, biterLink, sgEnable;
  logic [5:0]  chkChan, busChan;
  logic [2:0]  srcSize, dstSize;
  logic [31:0] dstAddr, minorBytes, sgNextAddr;
  logic [15:0] dstOff, citer;
  logic        rdBusErr, wrBusErr, clrStat;
  logic [5:0]  errFlags, errChan;
  logic        errValid;

  int checks = 0;
  int failures = 0;
  bit modelOn = 0;
  int cycles = 0;

  logic [5:0] mFlags = '0;
  logic [5:0] mChan = '0;
  logic       mValid = 1'b0;

  always #10 clk = ~clk;

  dma_desc_err_check u0 (
    .clk(clk), .rstN(rstN), .chkValid(chkValid), .chkChan(chkChan),
    .chkSgLoad(chkSgLoad), .srcSize(srcSize), .dstSize(dstSize),
    .dstAddr(dstAddr), .dstOff(dstOff), .minorBytes(minorBytes),
    .citer(citer), .biterLink(biterLink), .sgEnable(sgEnable),
    .sgNextAddr(sgNextAddr), .rdBusErr(rdBusErr), .wrBusErr(wrBusErr),
    .busChan(busChan), .clrStat(clrStat), .errFlags(errFlags),
    .errChan(errChan), .errValid(errValid)
  );

  function automatic int bytesOf(input logic [2:0] code);
    if (code == 3'd3) return 32;
    if (code < 3'd3) return 1 << code;
    return 0;
  endfunction

  function automatic logic [5:0] refCheck();
    logic [5:0] f = '0;
    int sb = bytesOf(srcSize);
    int db = bytesOf(dstSize);
    if (db != 0) begin
      if ((dstAddr % db) != 0) f[0] = 1'b1;
      if ((int'(dstOff) % db) != 0) f[1] = 1'b1;
    end
    if (sb == 0 || db == 0) f[2] = 1'b1;
    else if ((minorBytes % sb) != 0 || (minorBytes % db) != 0) f[2] = 1'b1;
    if (citer[14:0] == 0) f[2] = 1'b1;
    if (citer[15] != biterLink) f[2] = 1'b1;
    if (chkSgLoad && sgEnable && (sgNextAddr % 32) != 0) f[3] = 1'b1;
    return f;
  endfunction

  // reference model, updated on each clock
  always @(posedge clk) begin
    logic [5:0] cf;
    cf = refCheck();
    if (!rstN) begin
      mFlags = '0; mChan = '0; mValid = 1'b0;
    end else if (rdBusErr || wrBusErr) begin
      mFlags = {wrBusErr, rdBusErr, 4'b0000}; mChan = busChan; mValid = 1'b1;
    end else if (chkValid && cf != 0) begin
      mFlags = cf; mChan = chkChan; mValid = 1'b1;
    end else if (clrStat) begin
      mFlags = '0; mChan = '0; mValid = 1'b0;
    end
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=20000 cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // model compare on every cycle (R9, R11)
  always @(negedge clk) begin
    if (modelOn) begin
      checks++;
      if (errFlags !== mFlags || errChan !== mChan || errValid !== mValid) begin
        failures++;
        $display("FAIL R9 model: actual flags=%b chan=%0d valid=%b expected flags=%b chan=%0d valid=%b",
                 errFlags, errChan, errValid, mFlags, mChan, mValid);
      end
    end
  end

  task automatic expectNow(input string tag, input logic [5:0] f,
                           input logic [5:0] c, input logic v);
    checks++;
    if (errFlags !== f || errChan !== c || errValid !== v) begin
      failures++;
      $display("FAIL %s: actual flags=%b chan=%0d valid=%b expected flags=%b chan=%0d valid=%b",
               tag, errFlags, errChan, errValid, f, c, v);
    end
  endtask

  task automatic idle();
    chkValid = 0; chkChan = 0; chkSgLoad = 0; srcSize = 3'd2; dstSize = 3'd2;
    dstAddr = 32'h100; dstOff = 16'd4; minorBytes = 32'd8; citer = 16'd2;
    biterLink = 0; sgEnable = 0; sgNextAddr = 0; rdBusErr = 0; wrBusErr = 0;
    busChan = 0; clrStat = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runDesc(input logic [5:0] ch);
    chkValid = 1; chkChan = ch;
    cyc();
    idle();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectNow("R11 reset", 6'b0, 6'd0, 1'b0);
    modelOn = 1;

    dstAddr = 32'h1002; runDesc(6'd5);
    expectNow("R1 dst addr 4B", 6'b000001, 6'd5, 1'b1);

    dstSize = 3'd1; dstAddr = 32'h10; dstOff = 16'd3; minorBytes = 4; runDesc(6'd7);
    expectNow("R2 dst offset / R9 replace", 6'b000010, 6'd7, 1'b1);

    srcSize = 3'd0; minorBytes = 6; runDesc(6'd8);
    expectNow("R3 byte count", 6'b000100, 6'd8, 1'b1);

    citer = 16'h8000; biterLink = 1; runDesc(6'd9);
    expectNow("R4 zero iteration", 6'b000100, 6'd9, 1'b1);

    citer = 16'd5; biterLink = 1; runDesc(6'd10);
    expectNow("R5 link mismatch", 6'b000100, 6'd10, 1'b1);

    srcSize = 3'd5; runDesc(6'd11);
    expectNow("R6 reserved src", 6'b000100, 6'd11, 1'b1);

    dstSize = 3'd6; dstAddr = 32'h1; dstOff = 16'd1; runDesc(6'd12);
    expectNow("R6 reserved dst skips addr", 6'b000100, 6'd12, 1'b1);

    dstSize = 3'd3; dstAddr = 32'h10; dstOff = 16'd8; minorBytes = 16; runDesc(6'd13);
    expectNow("R1 32B size multi-flag", 6'b000111, 6'd13, 1'b1);

    sgEnable = 1; chkSgLoad = 1; sgNextAddr = 32'h1010; runDesc(6'd14);
    expectNow("R7 sg misaligned", 6'b001000, 6'd14, 1'b1);

    sgEnable = 1; chkSgLoad = 0; sgNextAddr = 32'h1010; runDesc(6'd15);
    expectNow("R7 sg no load ignored", 6'b001000, 6'd14, 1'b1);

    sgEnable = 0; chkSgLoad = 1; sgNextAddr = 32'h1004; runDesc(6'd16);
    expectNow("R7 sg disabled ignored", 6'b001000, 6'd14, 1'b1);

    sgEnable = 1; chkSgLoad = 1; sgNextAddr = 32'h1020; runDesc(6'd17);
    expectNow("R9 clean check keeps", 6'b001000, 6'd14, 1'b1);

    rdBusErr = 1; busChan = 6'd20; cyc(); idle();
    expectNow("R8 read bus", 6'b010000, 6'd20, 1'b1);

    wrBusErr = 1; busChan = 6'd21; cyc(); idle();
    expectNow("R8 write bus", 6'b100000, 6'd21, 1'b1);

    rdBusErr = 1; wrBusErr = 1; busChan = 6'd22; cyc(); idle();
    expectNow("R8 both bus", 6'b110000, 6'd22, 1'b1);

    wrBusErr = 1; busChan = 6'd23; dstAddr = 32'h3; runDesc(6'd30);
    expectNow("R8 bus beats check", 6'b100000, 6'd23, 1'b1);

    clrStat = 1; cyc(); idle();
    expectNow("R10 clear", 6'b0, 6'd0, 1'b0);

    rdBusErr = 1; busChan = 6'd40; cyc(); idle();
    clrStat = 1; dstAddr = 32'h2; runDesc(6'd41);
    expectNow("R10 error beats clear", 6'b000001, 6'd41, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      chkValid   = ($urandom % 2) == 0;
      chkChan    = 6'($urandom);
      chkSgLoad  = ($urandom % 2) == 0;
      sgEnable   = ($urandom % 2) == 0;
      srcSize    = (($urandom % 8) == 0) ? 3'($urandom) : 3'($urandom % 4);
      dstSize    = (($urandom % 8) == 0) ? 3'($urandom) : 3'($urandom % 4);
      dstAddr    = (($urandom % 2) == 0) ? ($urandom & 32'hFFFF_FFE0) : $urandom;
      dstOff     = (($urandom % 2) == 0) ? 16'($urandom & 32'hFFE0) : 16'($urandom);
      minorBytes = (($urandom % 2) == 0) ? ($urandom & 32'h0000_FFE0) : $urandom;
      citer      = (($urandom % 6) == 0) ? {1'($urandom), 15'd0} : 16'($urandom);
      biterLink  = (($urandom % 3) == 0) ? ~citer[15] : citer[15];
      sgNextAddr = (($urandom % 2) == 0) ? ($urandom & 32'hFFFF_FFE0) : $urandom;
      rdBusErr   = ($urandom % 10) == 0;
      wrBusErr   = ($urandom % 10) == 0;
      busChan    = 6'($urandom);
      clrStat    = ($urandom % 12) == 0;
      cyc();
    end
    idle();
    cyc();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule